// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Port

This block is the byte-wide host register port of a two-channel serial controller. Each channel has a control address and a data address. Address bit 1 picks the channel: 1 selects channel A and 0 selects channel B. Address bit 0 picks control (0) or data (1). Each channel holds sixteen write registers and sixteen read registers. The host reaches them through a per-channel register pointer in two steps. A control write with the pointer at zero loads the pointer and may carry a command. The next control access then reaches the selected register, and the pointer falls back to zero.

Write register 9 carries software reset commands. Each reset restores the per-channel defaults: write register 4 is 0x04, 9 is 0xC0, 11 is 0x08, 14 is 0x30, 15 is 0xF8, and every other write register is 0. The block decodes the line parameters from the write registers and brings them out as ports. These are the baud divisor, parity, stop bits, data bits and clock multiplier. A later stage derives the bit rate from them as (clock / 2) / (divisor + 2) >> clk_shift. Serial shifting and interrupt vectoring belong to other blocks.

Top module: `sccp_top`

## Requirements
- R1: After reset, a control read with the pointer at zero returns 0x44 from read register 0, or 0x7C on a channel whose DISABLED parameter bit is set. Read register 1 returns 0x07 and the divisor output is 0.
- R2: With the pointer at zero, a control write loads wdata[2:0] as the next register number. When wdata[5:3] equals 3'b001, 8 is added to that number. Any other command code adds nothing.
- R3: After a control write with the pointer non-zero, or after any control read, the pointer returns to zero.
- R4: A write to register 9 acts on wdata[7:6]. 01 resets channel B only, 10 resets channel A only, 11 resets both channels and 00 resets nothing. A reset channel returns to its R1 and R5 state, including pointer 0.
- R5: After any reset, the outputs show no parity, one stop bit, a x1 multiplier (clk_shift 0) and 5 data bits.
- R6: A write to register 12 or 13 sets the low or high byte of the divisor output. The same byte then reads back from read register 12 or 13.
- R7: In write register 4, bit 0 enables parity and bit 1 selects even parity. Bits 3:2 equal to 11 select two stop bits. Bits 7:6 give clk_shift: 00 gives 0, 01 gives 4, 10 gives 5 and 11 gives 6.
- R8: Write register 5 bits 6:5 give the data bits: 00 gives 5, 01 gives 7, 10 gives 6 and 11 gives 8.
- R9: A data-address access leaves the pointer unchanged, and a data-address read returns 0.
- R10: An access to one channel leaves the pointer, registers and outputs of the other channel unchanged. Output vector index 1 is channel A and index 0 is channel B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Bit 1 channel (1 = A), bit 0 data (1) / control (0) |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid during rd_i |
| divisor_o | output | 2x16 | Baud divisor per channel |
| parity_en_o | output | 2 | Parity enabled |
| parity_even_o | output | 2 | Even parity selected |
| two_stop_o | output | 2 | Two stop bits |
| data_bits_o | output | 2x4 | Character length in bits |
| clk_shift_o | output | 2x3 | Clock multiplier as a right shift |

## Verification
Read data is combinational during the read strobe. The bench drives each access on a falling edge and samples rdata_o 1 ns later, before the rising edge that moves the pointer. Register writes, pointer loads and software resets all take effect at the rising edge that ends the strobe. The decoded outputs are therefore compared at the following falling edge, one full access later. The bench sweeps all 256 values of register 4, the four character lengths and several divisor patterns on both channels, and checks each against arithmetic of its own.

// File: rtl/sccp_pkg.sv
package sccp_pkg;
  localparam int NCH = 2;
  localparam int NREG = 16;
  localparam int DW = 8;

  function automatic logic [DW-1:0] wr_default(input int idx);
    case (idx)
      4: wr_default = 8'h04;
      9: wr_default = 8'hC0;
      11: wr_default = 8'h08;
      14: wr_default = 8'h30;
      15: wr_default = 8'hF8;
      default: wr_default = '0;
    endcase
  endfunction
endpackage

// File: rtl/sccp_chan.sv
module sccp_chan
  import sccp_pkg::*;
#(
  parameter bit DIS = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_wr_i,
  input  logic          ctl_rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          soft_rst_i,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    rst_req_o,
  output logic [DW-1:0] wr4_o,
  output logic [DW-1:0] wr5_o,
  output logic [DW-1:0] wr12_o,
  output logic [DW-1:0] wr13_o
);
  localparam int PW = $clog2(NREG);
  localparam int HI = NREG / 2;
  localparam logic [DW-1:0] RR0_RST = DIS ? 8'h7C : 8'h44;
  localparam logic [DW-1:0] RR1_RST = 8'h07;

  logic [PW-1:0] ptr_q;
  logic [DW-1:0] wreg_q [NREG];
  logic [DW-1:0] rr12_q, rr13_q;
  logic          cmd_hi;

  assign cmd_hi = (wdata_i[5:3] == 3'd1);
  assign rst_req_o = (ctl_wr_i && ptr_q == PW'(9)) ? wdata_i[7:6] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      rr12_q <= '0;
      rr13_q <= '0;
      for (int i = 0; i < NREG; i++) wreg_q[i] <= wr_default(i);
    end else if (soft_rst_i) begin
      ptr_q <= '0;
      rr12_q <= '0;
      rr13_q <= '0;
      for (int i = 0; i < NREG; i++) wreg_q[i] <= wr_default(i);
    end else if (ctl_wr_i) begin
      if (ptr_q == '0) begin
        ptr_q <= PW'(wdata_i[2:0]) + (cmd_hi ? PW'(HI) : PW'(0));
      end else begin
        if (ptr_q != PW'(9)) wreg_q[ptr_q] <= wdata_i;
        if (ptr_q == PW'(12)) rr12_q <= wdata_i;
        if (ptr_q == PW'(13)) rr13_q <= wdata_i;
        ptr_q <= '0;
      end
    end else if (ctl_rd_i) begin
      ptr_q <= '0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ctl_rd_i) begin
      case (ptr_q)
        PW'(0):  rdata_o = RR0_RST;
        PW'(1):  rdata_o = RR1_RST;
        PW'(12): rdata_o = rr12_q;
        PW'(13): rdata_o = rr13_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign wr4_o = wreg_q[4];
  assign wr5_o = wreg_q[5];
  assign wr12_o = wreg_q[12];
  assign wr13_o = wreg_q[13];

  p_ptr_return_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctl_wr_i && ptr_q != '0) || ctl_rd_i) |=> ptr_q == '0);
  p_hi_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && ptr_q == '0 && cmd_hi && !soft_rst_i) |=> ptr_q[PW-1]);
  p_echo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && ptr_q == PW'(12) && !soft_rst_i) |=> rr12_q == $past(wdata_i));
  p_soft_rst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (ptr_q == '0 && wr4_o == 8'h04 && rr13_q == '0));
endmodule

// File: rtl/sccp_decode.sv
module sccp_decode
  import sccp_pkg::*;
(
  input  logic [DW-1:0] wr4_i,
  input  logic [DW-1:0] wr5_i,
  input  logic [DW-1:0] wr12_i,
  input  logic [DW-1:0] wr13_i,
  output logic [15:0]   divisor_o,
  output logic          parity_en_o,
  output logic          parity_even_o,
  output logic          two_stop_o,
  output logic [3:0]    data_bits_o,
  output logic [2:0]    clk_shift_o
);
  assign divisor_o = {wr13_i, wr12_i};
  assign parity_en_o = wr4_i[0];
  assign parity_even_o = wr4_i[1];
  assign two_stop_o = (wr4_i[3:2] == 2'b11);

  always_comb begin
    case (wr5_i[6:5])
      2'b00: data_bits_o = 4'd5;
      2'b01: data_bits_o = 4'd7;
      2'b10: data_bits_o = 4'd6;
      default: data_bits_o = 4'd8;
    endcase
    case (wr4_i[7:6])
      2'b00: clk_shift_o = 3'd0;
      2'b01: clk_shift_o = 3'd4;
      2'b10: clk_shift_o = 3'd5;
      default: clk_shift_o = 3'd6;
    endcase
  end

  always_comb begin
    a_len_r8: assert (data_bits_o >= 4'd5 && data_bits_o <= 4'd8);
  end
endmodule

// File: rtl/sccp_top.sv
module sccp_top
  import sccp_pkg::*;
#(
  parameter logic [NCH-1:0] DISABLED = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [NCH-1:0][15:0] divisor_o,
  output logic [NCH-1:0]       parity_en_o,
  output logic [NCH-1:0]       parity_even_o,
  output logic [NCH-1:0]       two_stop_o,
  output logic [NCH-1:0][3:0]  data_bits_o,
  output logic [NCH-1:0][2:0]  clk_shift_o
);
  logic [NCH-1:0][DW-1:0] ch_rdata;
  logic [NCH-1:0][1:0]    ch_req;
  logic [NCH-1:0]         soft_rst;
  logic                   is_ctl;

  assign is_ctl = ~addr_i[0];

  // index 0 = channel B, index 1 = channel A; request bit k resets channel k
  always_comb begin
    soft_rst = '0;
    for (int c = 0; c < NCH; c++) soft_rst = soft_rst | ch_req[c];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    logic [DW-1:0] w4, w5, w12, w13;
    assign sel = (addr_i[1] == 1'(c));

    sccp_chan #(.DIS(DISABLED[c])) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctl_wr_i  (wr_i && sel && is_ctl),
      .ctl_rd_i  (rd_i && sel && is_ctl),
      .wdata_i   (wdata_i),
      .soft_rst_i(soft_rst[c]),
      .rdata_o   (ch_rdata[c]),
      .rst_req_o (ch_req[c]),
      .wr4_o     (w4),
      .wr5_o     (w5),
      .wr12_o    (w12),
      .wr13_o    (w13)
    );

    sccp_decode u_dec (
      .wr4_i        (w4),
      .wr5_i        (w5),
      .wr12_i       (w12),
      .wr13_i       (w13),
      .divisor_o    (divisor_o[c]),
      .parity_en_o  (parity_en_o[c]),
      .parity_even_o(parity_even_o[c]),
      .two_stop_o   (two_stop_o[c]),
      .data_bits_o  (data_bits_o[c]),
      .clk_shift_o  (clk_shift_o[c])
    );
  end

  // data-address reads return 0: no receive path here
  assign rdata_o = ch_rdata[addr_i[1]];

  p_one_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && rd_i));
  p_data_rd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[0]) |-> rdata_o == '0);
endmodule

// File: tb/sccp_top_test.sv
`timescale 1ns/1ps
module sccp_top_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] addr = '0;
  logic wr = 0, rd = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0][15:0] divisor;
  logic [1:0] par_en, par_ev, two_stop;
  logic [1:0][3:0] dbits;
  logic [1:0][2:0] cshift;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sccp_top #(.DISABLED(2'b10)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .divisor_o(divisor),
    .parity_en_o(par_en), .parity_even_o(par_ev), .two_stop_o(two_stop),
    .data_bits_o(dbits), .clk_shift_o(cshift)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ch: 1 = A, 0 = B
  task automatic cwr(input int ch, input logic [7:0] v);
    @(negedge clk);
    addr = {1'(ch), 1'b0}; wdata = v; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic dwr(input int ch, input logic [7:0] v);
    @(negedge clk);
    addr = {1'(ch), 1'b1}; wdata = v; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic crd(input int ch, output logic [7:0] v);
    @(negedge clk);
    addr = {1'(ch), 1'b0}; rd = 1;
    #1 v = rdata;
    @(negedge clk);
    rd = 0;
  endtask

  task automatic drd(input int ch, output logic [7:0] v);
    @(negedge clk);
    addr = {1'(ch), 1'b1}; rd = 1;
    #1 v = rdata;
    @(negedge clk);
    rd = 0;
  endtask

  // write a register through the pointer protocol
  task automatic wreg(input int ch, input int r, input logic [7:0] v);
    cwr(ch, 8'((r & 7) | ((r >= 8) ? 8'h08 : 8'h00)));
    cwr(ch, v);
  endtask

  task automatic rreg(input int ch, input int r, output logic [7:0] v);
    cwr(ch, 8'((r & 7) | ((r >= 8) ? 8'h08 : 8'h00)));
    crd(ch, v);
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int exp_shift, exp_bits;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 / R5 reset state
    crd(1, v); chk("R1 rr0 A disabled", v, 8'h7C);
    crd(0, v); chk("R1 rr0 B", v, 8'h44);
    rreg(0, 1, v); chk("R1 rr1 B", v, 8'h07);
    rreg(1, 1, v); chk("R1 rr1 A", v, 8'h07);
    for (int c = 0; c < 2; c++) begin
      chk("R1 divisor", divisor[c], 0);
      chk("R5 parity", {par_en[c], par_ev[c]}, 0);
      chk("R5 stop", two_stop[c], 0);
      chk("R5 shift", cshift[c], 0);
      chk("R5 bits", dbits[c], 5);
    end

    // R6 divisor echo, both channels, several patterns
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 8; k++) begin
        logic [15:0] d;
        d = 16'((k * 16'h2F3B) ^ (c << 15) ^ (16'h1 << k));
        wreg(c, 12, d[7:0]);
        wreg(c, 13, d[15:8]);
        chk("R6 divisor_o", divisor[c], d);
        rreg(c, 12, v); chk("R6 rr12", v, d[7:0]);
        rreg(c, 13, v); chk("R6 rr13", v, d[15:8]);
      end

    // R7 sweep register 4 on channel B; R10 channel A unaffected
    for (int x = 0; x < 256; x++) begin
      wreg(0, 4, 8'(x));
      chk("R7 par_en", par_en[0], x & 1);
      chk("R7 par_even", par_ev[0], (x >> 1) & 1);
      chk("R7 two_stop", two_stop[0], ((x >> 2) & 3) == 3);
      exp_shift = ((x >> 6) == 0) ? 0 : 3 + (x >> 6);
      chk("R7 clk_shift", cshift[0], exp_shift);
      chk("R10 A shift untouched", cshift[1], 0);
    end

    // R8 character length, both channels
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < 4; k++) begin
        wreg(c, 5, 8'(k << 5));
        exp_bits = (k == 0) ? 5 : (k == 1) ? 7 : (k == 2) ? 6 : 8;
        chk("R8 data_bits", dbits[c], exp_bits);
      end

    // R2 non-hi command does not add 8: 0x2C -> ptr 4, read 0
    wreg(1, 12, 8'hA5);
    cwr(1, 8'h2C); crd(1, v); chk("R2 other cmd no hi", v, 8'h00);
    cwr(1, 8'h0C); crd(1, v); chk("R2 hi cmd ptr12", v, 8'hA5);

    // R3 pointer returns after read and after write
    cwr(1, 8'h0C); crd(1, v); crd(1, v); chk("R3 after read", v, 8'h7C);
    wreg(1, 12, 8'h5A); crd(1, v); chk("R3 after write", v, 8'h7C);
    chk("R3 write landed", divisor[1][7:0], 8'h5A);

    // R9 data accesses leave pointer, data read returns 0
    cwr(0, 8'h0C); dwr(0, 8'h99); drd(0, v); chk("R9 data rd zero", v, 0);
    crd(0, v); chk("R9 ptr kept", v, divisor[0][7:0]);

    // R10 pointer of A unaffected by access to B
    cwr(1, 8'h01); crd(0, v); crd(1, v); chk("R10 A ptr kept", v, 8'h07);

    // R4 reset codes
    wreg(0, 12, 8'h11); wreg(1, 12, 8'h22);
    wreg(1, 9, 8'h00);
    chk("R4 00 keeps B", divisor[0], 16'h0011 | (divisor[0] & 16'hFF00));
    chk("R4 00 keeps A lo", divisor[1][7:0], 8'h22);
    wreg(1, 9, 8'h40);
    chk("R4 01 resets B", divisor[0], 0);
    chk("R4 01 keeps A", divisor[1][7:0], 8'h22);
    wreg(0, 12, 8'h33); wreg(1, 4, 8'hC3);
    wreg(0, 9, 8'h80);
    chk("R4 10 resets A", divisor[1], 0);
    chk("R5 A shift", cshift[1], 0);
    chk("R5 A parity", par_en[1], 0);
    chk("R4 10 keeps B", divisor[0][7:0], 8'h33);
    wreg(1, 12, 8'h44); wreg(0, 5, 8'h60);
    wreg(0, 9, 8'hC0);
    chk("R4 11 B", divisor[0], 0);
    chk("R4 11 A", divisor[1], 0);
    chk("R5 B bits", dbits[0], 5);
    rreg(1, 12, v); chk("R4 rr12 cleared", v, 0);
    cwr(0, 8'h01); wreg(1, 9, 8'h40); crd(0, v); chk("R4 B ptr reset", v, 8'h44);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule